// File: doc/BRIEF.md
# Flash Card Block-Transfer Register Front End

This block is the software-facing side of a controller that moves whole 512-byte blocks to and from a removable flash card. A processor reaches it through a simple 32-bit register slave: a select, a write strobe, a three-bit word offset and combinational read data. The block holds six registers: a clock divider, a block address, a streaming data port, a command register, a transfer size and a status word. It also owns the block buffer. Software fills the buffer one word at a time before a write, or drains it one word at a time after a read.

On the other side, a card engine handles command framing, CRCs and clock switching. The engine sees a one-cycle start pulse with the command, block number and size. It answers later with a one-cycle done pulse and a fault bit. During a block read it pushes words into the buffer with a valid strobe. During a block write it fetches words through its own read port. A single interrupt line is the OR of two sticky flags. One flag is set when an operation completes. The other is set when software issues a command while the engine is still busy.

Top module: `sdfe_front`

## Requirements
- R1: After reset the status word reads 0, `irq` and `be_start` are low, and the divider register reads the `DIV_INIT` value (default 3).
- R2: Register word offsets are: divider 0, block address 1, data 2, command 3, size 4, status 5.
  - Offsets 6 and 7 read 0, and writes to them have no effect.
  - The divider reads back its low `DIV_W` bits and drives `clk_div`.
  - The size register reads back its low 12 bits and drives `be_size`.
  - The command register reads back the last accepted command.
- R3: The block address register keeps only bits 31:9 of the written word. It reads back with bits 8:0 as zero, and `be_blk` carries bits 31:9.
- R4: Command code 1 means read block and code 2 means write block. When either code is written while the block is idle:
  - `be_start` is high for exactly the next cycle, with `be_cmd` equal to the code.
  - The busy flag (status bit 31) becomes set.
- R5: Command codes 0 and 3 written while idle are ignored: no start pulse is sent and busy stays clear.
- R6: A command write while busy is not forwarded to the engine. Busy stays set and the bus-error interrupt flag is raised.
- R7: A done pulse while busy has three effects:
  - busy clears;
  - status bit 30 takes the fault bit;
  - the completion interrupt flag is raised.

  The fault flag clears when the next command is accepted. A done pulse while idle changes nothing.
- R8: A write to the status register clears flags: a 1 in bit 0 clears the completion flag and a 1 in bit 1 clears the bus-error flag. A flag that is set and cleared in the same cycle stays set. `irq` is the OR of the two flags.
- R9: Status bits 11:0 give the byte count held in the buffer, and bits 29:12 read 0.
- R10: While idle, each data-register write stores the word at the software pointer and advances the pointer by one. The byte count grows by 4 and saturates at 512. Data writes while busy are ignored.
- R11: Each data-register read returns the word at the software pointer and advances the pointer.
  - Words at or beyond the filled byte count read 0.
  - The pointer stops at 128 and does not wrap.
- R12: Accepting a command resets both buffer pointers. A read command also clears the byte count, while a write command keeps it. During a read, each engine word strobe fills the next buffer word in order and adds 4 to the count.
- R13: `be_rdata` gives the buffer word addressed by `be_raddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Pending completion or bus-error interrupt |
| clk_div | output | DIV_W | Divider setting for the card clock |
| be_start | output | 1 | One-cycle start pulse to the engine |
| be_cmd | output | 2 | Accepted command code |
| be_blk | output | 23 | Block number (address bits 31:9) |
| be_size | output | 12 | Transfer size in bytes |
| be_done | input | 1 | Engine completion pulse |
| be_fault | input | 1 | Fault bit qualifying `be_done` |
| be_wvalid | input | 1 | Engine buffer word strobe during a read |
| be_wdata | input | 32 | Engine buffer word |
| be_raddr | input | 7 | Engine buffer read index during a write |
| be_rdata | output | 32 | Buffer word at `be_raddr` |

## Verification
The assertions watch the engine handshake on every cycle. They check that a start pulse lasts one cycle and carries a legal code, and that busy rises only together with a start. They also check that busy holds until a done pulse, that a done or a rejected command leaves an interrupt pending, and that the byte count never passes 512. Other behaviours appear only as the result of ordered bus traffic, so only the bench scenarios can show them:
- which flags a status write clears;
- what the streaming data port returns past the fill level or past the last word;
- that a data write during a busy period leaves the buffer intact;
- that a read command clears the count while a write command keeps it.

// File: rtl/sdfe_pkg.sv
package sdfe_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        OFF_DIV  = 3'd0,
        OFF_BLK  = 3'd1,
        OFF_DATA = 3'd2,
        OFF_CMD  = 3'd3,
        OFF_SIZE = 3'd4,
        OFF_STAT = 3'd5
    } reg_off_e;

    localparam int STAT_CNT_W     = 12;
    localparam int STAT_FAULT_BIT = 30;
    localparam int STAT_BUSY_BIT  = 31;

endpackage

// File: rtl/sdfe_regs.sv
module sdfe_regs
    import sdfe_pkg::*;
#(
    parameter int               DIV_W    = 8,
    parameter logic [DIV_W-1:0] DIV_INIT = 3,
    parameter int               BLK_W    = 23,
    parameter int               SIZE_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_div,
    input  logic              wr_blk,
    input  logic              wr_size,
    input  logic              wr_cmd,
    input  logic [31:0]       wdata,
    input  logic              be_done,
    input  logic              be_fault,
    output logic [DIV_W-1:0]  div,
    output logic [BLK_W-1:0]  blk,
    output logic [SIZE_W-1:0] size,
    output logic [1:0]        cmd,
    output logic              busy,
    output logic              fault,
    output logic              start,
    output logic              accept,
    output logic              reject
);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [BLK_W-1:0]  blk;
        logic [SIZE_W-1:0] size;
        cmd_e              cmd;
        logic              busy;
        logic              fault;
        logic              start;
    } regs_t;

    regs_t      st_d, st_q;
    logic [1:0] code;
    logic       code_ok;

    always_comb begin
        code    = wdata[1:0];
        code_ok = (code == CMD_READ) || (code == CMD_WRITE);
        accept  = wr_cmd && !st_q.busy && code_ok;
        reject  = wr_cmd && st_q.busy;

        st_d       = st_q;
        st_d.start = 1'b0;
        if (wr_div)  st_d.div  = wdata[DIV_W-1:0];
        if (wr_blk)  st_d.blk  = wdata[31 -: BLK_W];
        if (wr_size) st_d.size = wdata[SIZE_W-1:0];
        if (accept) begin
            st_d.cmd   = cmd_e'(code);
            st_d.busy  = 1'b1;
            st_d.fault = 1'b0;
            st_d.start = 1'b1;
        end else if (st_q.busy && be_done) begin
            st_d.busy  = 1'b0;
            st_d.fault = be_fault;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.div   <= DIV_INIT;
            st_q.cmd   <= CMD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign div   = st_q.div;
    assign blk   = st_q.blk;
    assign size  = st_q.size;
    assign cmd   = st_q.cmd;
    assign busy  = st_q.busy;
    assign fault = st_q.fault;
    assign start = st_q.start;

endmodule

// File: rtl/sdfe_buf.sv
module sdfe_buf #(
    parameter int WORDS = 128,
    parameter int CNT_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept,
    input  logic                     clr_count,
    input  logic                     sw_wr,
    input  logic                     sw_rd,
    input  logic [31:0]              sw_wdata,
    output logic [31:0]              sw_rdata,
    input  logic                     be_we,
    input  logic [31:0]              be_wdata,
    input  logic [$clog2(WORDS)-1:0] be_raddr,
    output logic [31:0]              be_rdata,
    output logic [CNT_W-1:0]         count
);

    localparam int               IDX_W   = $clog2(WORDS);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORDS * 4);
    localparam logic [CNT_W-1:0] STEP    = CNT_W'(4);

    typedef struct packed {
        logic [IDX_W:0]   sw_ptr;
        logic [IDX_W:0]   be_ptr;
        logic [CNT_W-1:0] count;
    } buf_t;

    buf_t             st_d, st_q;
    logic [31:0]      mem_q [WORDS];
    logic             mem_we;
    logic [IDX_W-1:0] mem_idx;
    logic [31:0]      mem_wd;
    logic             sw_hit;

    always_comb begin
        st_d    = st_q;
        mem_we  = 1'b0;
        mem_idx = '0;
        mem_wd  = '0;
        if (accept) begin
            st_d.sw_ptr = '0;
            st_d.be_ptr = '0;
            if (clr_count) st_d.count = '0;
        end else begin
            if (be_we && !st_q.be_ptr[IDX_W]) begin
                mem_we      = 1'b1;
                mem_idx     = st_q.be_ptr[IDX_W-1:0];
                mem_wd      = be_wdata;
                st_d.be_ptr = st_q.be_ptr + 1'b1;
                if (st_q.count < CNT_MAX) st_d.count = st_q.count + STEP;
            end else if (sw_wr && !st_q.sw_ptr[IDX_W]) begin
                mem_we      = 1'b1;
                mem_idx     = st_q.sw_ptr[IDX_W-1:0];
                mem_wd      = sw_wdata;
                st_d.sw_ptr = st_q.sw_ptr + 1'b1;
                if (st_q.count < CNT_MAX) st_d.count = st_q.count + STEP;
            end
            if (sw_rd && !st_q.sw_ptr[IDX_W]) begin
                st_d.sw_ptr = st_q.sw_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[mem_idx] <= mem_wd;
    end

    assign sw_hit   = !st_q.sw_ptr[IDX_W] && (CNT_W'({st_q.sw_ptr, 2'b00}) < st_q.count);
    assign sw_rdata = sw_hit ? mem_q[st_q.sw_ptr[IDX_W-1:0]] : 32'd0;
    assign be_rdata = mem_q[be_raddr];
    assign count    = st_q.count;

endmodule

// File: rtl/sdfe_irq.sv
module sdfe_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_err,
    input  logic clr_done,
    input  logic clr_err,
    output logic irq
);

    typedef struct packed {
        logic done;
        logic err;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d.done = (fl_q.done && !clr_done) || set_done;
        fl_d.err  = (fl_q.err  && !clr_err)  || set_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign irq = fl_q.done || fl_q.err;

endmodule

// File: rtl/sdfe_front.sv
module sdfe_front
    import sdfe_pkg::*;
#(
    parameter int               DIV_W       = 8,
    parameter logic [DIV_W-1:0] DIV_INIT    = 3,
    parameter int               BLOCK_BYTES = 512,
    parameter int               SIZE_W      = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [2:0]                        bus_off,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    output logic                              irq,
    output logic [DIV_W-1:0]                  clk_div,
    output logic                              be_start,
    output logic [1:0]                        be_cmd,
    output logic [31-$clog2(BLOCK_BYTES):0]   be_blk,
    output logic [SIZE_W-1:0]                 be_size,
    input  logic                              be_done,
    input  logic                              be_fault,
    input  logic                              be_wvalid,
    input  logic [31:0]                       be_wdata,
    input  logic [$clog2(BLOCK_BYTES/4)-1:0]  be_raddr,
    output logic [31:0]                       be_rdata
);

    localparam int WORDS  = BLOCK_BYTES / 4;
    localparam int OFFS_W = $clog2(BLOCK_BYTES);
    localparam int BLK_W  = 32 - OFFS_W;
    localparam int CNT_W  = STAT_CNT_W;

    logic              acc_wr, acc_rd;
    logic              wr_div, wr_blk, wr_size, wr_cmd, wr_stat, wr_data, rd_data;
    logic [DIV_W-1:0]  div;
    logic [BLK_W-1:0]  blk;
    logic [SIZE_W-1:0] size;
    logic [1:0]        cmd;
    logic              busy, fault, start, accept, reject;
    logic [31:0]       sw_rdata;
    logic [CNT_W-1:0]  count;
    logic              be_we;

    assign acc_wr  = bus_sel && bus_wr;
    assign acc_rd  = bus_sel && !bus_wr;
    assign wr_div  = acc_wr && (bus_off == OFF_DIV);
    assign wr_blk  = acc_wr && (bus_off == OFF_BLK);
    assign wr_size = acc_wr && (bus_off == OFF_SIZE);
    assign wr_cmd  = acc_wr && (bus_off == OFF_CMD);
    assign wr_stat = acc_wr && (bus_off == OFF_STAT);
    assign wr_data = acc_wr && (bus_off == OFF_DATA) && !busy;
    assign rd_data = acc_rd && (bus_off == OFF_DATA);
    assign be_we   = be_wvalid && busy && (cmd == CMD_READ);

    sdfe_regs #(
        .DIV_W    (DIV_W),
        .DIV_INIT (DIV_INIT),
        .BLK_W    (BLK_W),
        .SIZE_W   (SIZE_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_div   (wr_div),
        .wr_blk   (wr_blk),
        .wr_size  (wr_size),
        .wr_cmd   (wr_cmd),
        .wdata    (bus_wdata),
        .be_done  (be_done),
        .be_fault (be_fault),
        .div      (div),
        .blk      (blk),
        .size     (size),
        .cmd      (cmd),
        .busy     (busy),
        .fault    (fault),
        .start    (start),
        .accept   (accept),
        .reject   (reject)
    );

    sdfe_buf #(
        .WORDS (WORDS),
        .CNT_W (CNT_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .clr_count (bus_wdata[1:0] == CMD_READ),
        .sw_wr     (wr_data),
        .sw_rd     (rd_data),
        .sw_wdata  (bus_wdata),
        .sw_rdata  (sw_rdata),
        .be_we     (be_we),
        .be_wdata  (be_wdata),
        .be_raddr  (be_raddr),
        .be_rdata  (be_rdata),
        .count     (count)
    );

    sdfe_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_done (be_done && busy),
        .set_err  (reject),
        .clr_done (wr_stat && bus_wdata[0]),
        .clr_err  (wr_stat && bus_wdata[1]),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_off)
            OFF_DIV:  bus_rdata = 32'(div);
            OFF_BLK:  bus_rdata = {blk, {OFFS_W{1'b0}}};
            OFF_DATA: bus_rdata = sw_rdata;
            OFF_CMD:  bus_rdata = 32'(cmd);
            OFF_SIZE: bus_rdata = 32'(size);
            OFF_STAT: begin
                bus_rdata[CNT_W-1:0]     = count;
                bus_rdata[STAT_FAULT_BIT] = fault;
                bus_rdata[STAT_BUSY_BIT]  = busy;
            end
            default:  bus_rdata = '0;
        endcase
    end

    assign clk_div  = div;
    assign be_start = start;
    assign be_cmd   = cmd;
    assign be_blk   = blk;
    assign be_size  = size;

endmodule

// File: rtl/sdfe_front_chk.sv
module sdfe_front_chk #(
    parameter int CNT_MAX = 512
) (
    input logic        clk,
    input logic        rst_n,
    input logic        be_start,
    input logic [1:0]  be_cmd,
    input logic        be_done,
    input logic        busy,
    input logic        irq,
    input logic [11:0] count,
    input logic        rej
);

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |=> !be_start); // R4
    AST_START_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> (be_cmd == 2'd1 || be_cmd == 2'd2)); // R4
    AST_BUSY_ROSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> be_start); // R4
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !be_done) |=> busy); // R6
    AST_REJECT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        rej |=> irq); // R6
    AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && be_done) |=> (irq && !busy)); // R7
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= CNT_MAX); // R10

endmodule

bind sdfe_front sdfe_front_chk #(.CNT_MAX(BLOCK_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .be_start (be_start),
    .be_cmd   (be_cmd),
    .be_done  (be_done),
    .busy     (busy),
    .irq      (irq),
    .count    (count),
    .rej      (reject)
);

// File: tb/sdfe_front_tb.sv
module sdfe_front_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [7:0]  clk_div;
    logic        be_start;
    logic [1:0]  be_cmd;
    logic [22:0] be_blk;
    logic [11:0] be_size;
    logic        be_done = 1'b0, be_fault = 1'b0, be_wvalid = 1'b0;
    logic [31:0] be_wdata = '0;
    logic [6:0]  be_raddr = '0;
    logic [31:0] be_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    sdfe_front u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .clk_div(clk_div), .be_start(be_start), .be_cmd(be_cmd),
        .be_blk(be_blk), .be_size(be_size), .be_done(be_done),
        .be_fault(be_fault), .be_wvalid(be_wvalid), .be_wdata(be_wdata),
        .be_raddr(be_raddr), .be_rdata(be_rdata)
    );

    typedef struct packed {
        logic [2:0]  off;
        logic [31:0] wval;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 32'h0000_00AB, 32'h0000_00AB},
        '{3'd0, 32'hFFFF_FF5C, 32'h0000_005C},
        '{3'd1, 32'h1234_5FFF, 32'h1234_5E00},
        '{3'd4, 32'hFFFF_F123, 32'h0000_0123},
        '{3'd6, 32'hDEAD_BEEF, 32'h0000_0000},
        '{3'd7, 32'h0000_1234, 32'h0000_0000}
    };

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 | 32'(i * 3 + 1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_off = off;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic done_pulse(input logic f);
        @(negedge clk);
        be_done = 1'b1; be_fault = f;
        @(negedge clk);
        be_done = 1'b0; be_fault = 1'b0;
    endtask

    task automatic be_word(input logic [31:0] d);
        @(negedge clk);
        be_wvalid = 1'b1; be_wdata = d;
        @(negedge clk);
        be_wvalid = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000 && !ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd5, v);  check("R1 status", v, 32'h0);
        rd(3'd0, v);  check("R1 divider", v, 32'd3);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 start", 32'(be_start), 32'h0);

        // R2 / R3: register table
        foreach (VECS[i]) begin
            wr(VECS[i].off, VECS[i].wval);
            rd(VECS[i].off, v);
            check($sformatf("R2/R3 vector %0d", i), v, VECS[i].exp);
        end
        check("R3 be_blk", 32'(be_blk), 32'h1234_5FFF >> 9);
        check("R2 be_size", 32'(be_size), 32'h123);
        check("R2 clk_div", 32'(clk_div), 32'h5C);
        rd(3'd3, v);  check("R2 command idle", v, 32'h0);

        // R10: software fill of the whole block
        for (int i = 0; i < 128; i++) wr(3'd2, pat(i));
        rd(3'd5, v);  check("R10 full count", v, 32'h200);
        wr(3'd2, 32'hFFFF_0000);
        rd(3'd5, v);  check("R10 count saturates", v, 32'h200);
        // R11: pointer at end reads zero
        rd(3'd2, v);  check("R11 read at end", v, 32'h0);
        rd(3'd2, v);  check("R11 pointer stops", v, 32'h0);

        // R4: write block command
        wr(3'd1, 32'h00AB_C200);
        wr(3'd3, 32'd2);
        check("R4 start pulse", 32'(be_start), 32'h1);
        check("R4 cmd code", 32'(be_cmd), 32'h2);
        check("R4 block number", 32'(be_blk), 32'h00AB_C200 >> 9);
        @(negedge clk);
        check("R4 start one cycle", 32'(be_start), 32'h0);
        rd(3'd5, v);  check("R12 write keeps count", v, 32'h8000_0200);

        // R13: engine read port
        be_raddr = 7'd5;   #1 check("R13 word 5", be_rdata, pat(5));
        be_raddr = 7'd127; #1 check("R13 word 127", be_rdata, pat(127));

        // R10: data write while busy is ignored
        wr(3'd2, 32'hFFFF_FFFF);

        // R6: command while busy rejected
        wr(3'd3, 32'd1);
        check("R6 no start", 32'(be_start), 32'h0);
        check("R6 error irq", 32'(irq), 32'h1);
        rd(3'd5, v);  check("R6 still busy", v, 32'h8000_0200);
        wr(3'd5, 32'h2);
        check("R8 clear error", 32'(irq), 32'h0);

        // R7: done without fault
        done_pulse(1'b0);
        check("R7 done irq", 32'(irq), 32'h1);
        rd(3'd5, v);  check("R7 idle after done", v, 32'h0000_0200);
        wr(3'd5, 32'h1);
        check("R8 clear done", 32'(irq), 32'h0);
        rd(3'd2, v);  check("R12/R10 pointer reset, busy write ignored", v, pat(0));

        // R12: read block command with engine words
        wr(3'd3, 32'd1);
        check("R4 read start", 32'(be_start), 32'h1);
        check("R4 read code", 32'(be_cmd), 32'h1);
        rd(3'd5, v);  check("R12 read clears count", v, 32'h8000_0000);
        for (int i = 0; i < 3; i++) be_word(32'hB000_0000 + 32'(i));
        rd(3'd5, v);  check("R12 engine fill count", v, 32'h8000_000C);
        done_pulse(1'b1);
        rd(3'd5, v);  check("R9/R7 fault status", v, 32'h4000_000C);
        check("R7 fault done irq", 32'(irq), 32'h1);
        for (int i = 0; i < 3; i++) begin
            rd(3'd2, v);
            check($sformatf("R11 drain word %0d", i), v, 32'hB000_0000 + 32'(i));
        end
        rd(3'd2, v);  check("R11 past fill", v, 32'h0);
        wr(3'd5, 32'h3);
        check("R8 clear both", 32'(irq), 32'h0);
        rd(3'd3, v);  check("R2 command readback", v, 32'h1);

        // R7: done while idle ignored
        done_pulse(1'b0);
        check("R7 idle done no irq", 32'(irq), 32'h0);
        rd(3'd5, v);  check("R7 idle done status", v, 32'h4000_000C);

        // R5: codes 0 and 3 ignored
        wr(3'd3, 32'd0);
        check("R5 code 0 no start", 32'(be_start), 32'h0);
        wr(3'd3, 32'd3);
        check("R5 code 3 no start", 32'(be_start), 32'h0);
        rd(3'd5, v);  check("R5 not busy", v, 32'h4000_000C);
        check("R5 no irq", 32'(irq), 32'h0);

        // R8: set wins over clear in the same cycle
        wr(3'd3, 32'd2);
        rd(3'd5, v);  check("R7 fault cleared on accept", v, 32'h8000_000C);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_off = 3'd5; bus_wdata = 32'h1;
        be_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; be_done = 1'b0;
        check("R8 set beats clear", 32'(irq), 32'h1);

        // R1: reset again
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(3'd5, v);  check("R1 status after reset", v, 32'h0);
        rd(3'd0, v);  check("R1 divider after reset", v, 32'd3);
        check("R1 irq after reset", 32'(irq), 32'h0);

        finish_run();
    end

endmodule